// File: doc/BRIEF.md
# SHA-512 Compression Engine

This block performs the SHA-512 compression function on one pre-padded 1024-bit message block. The block and a 512-bit chaining value of eight 64-bit words go in. The updated 512-bit chaining value comes out. The engine is iterative and runs one round per clock for 80 rounds.

The block is loaded into a 16-word window. The window produces the 64-bit schedule word for each round as the rounds run, so the 80-word schedule is never stored in full. The 80 round constants are fixed when the design is elaborated: each one is the fractional part of the cube root of one of the first 80 primes.

A caller starts a block with a single-cycle pulse and waits for the done pulse. To hash several blocks, the caller feeds each digest back as the next chaining value. An option input replaces the supplied chaining value with the standard SHA-512 starting value, for the first block of a message.

Top module: `sha512_core`

## Requirements
- R1: Word 0 of the message is `block_i[1023:960]` and word 15 is `block_i[63:0]`. Chaining word H0 is `hv_i[511:448]` and H7 is `hv_i[63:0]`. `digest_o` uses the same word order as `hv_i`.
- R2: When `start_i` is high at a clock edge while `busy_o` is low, the engine captures its inputs and `busy_o` is high in the following cycle.
- R3: `busy_o` stays high for exactly 80 cycles. Then `done_o` is high for exactly one cycle, and `busy_o` is low during that cycle.
- R4: At `done_o`, `digest_o` equals the chaining input plus the 80-round working state, word by word, mod 2^64. Round t uses message word t for t < 16. For later t it uses σ1(W[t-2]) + W[t-7] + σ0(W[t-15]) + W[t-16].
- R5: When `init_hv_i` is high at the start edge, the engine uses the standard SHA-512 initial hash value in place of `hv_i`, and `hv_i` has no effect on the result.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running job keeps its timing and its result.
- R7: `digest_o` changes only in a cycle where `done_o` is high, and holds its value until the next completion.
- R8: After reset, `busy_o` and `done_o` are 0 and `digest_o` is all zeros.
- R9: With the standard initial value, the padded blocks for the empty message and for "abc" give the published SHA-512 digests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a compression when idle |
| init_hv_i | input | 1 | Use the standard initial hash value instead of hv_i |
| block_i | input | 1024 | Message block, word 0 in the top bits |
| hv_i | input | 512 | Chaining value, H0 in the top bits |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle completion pulse |
| digest_o | output | 512 | Updated chaining value, held between completions |

## Verification
The assertions assume that reset is asserted across at least one clock edge, so the first sampled history is the reset state. They also assume `start_i` is never unknown. The rules they check cover handshake timing and output stability only, so they do not depend on data values. The bench drives every input on the falling edge and uses one-cycle start pulses. It injects a start during a running job only deliberately, to exercise R6. Its digest model builds its round constants by its own integer Newton cube root. That model is tied to the published vectors for the empty message and "abc".

// File: rtl/sha512_pkg.sv
package sha512_pkg;
  localparam int WORD_W    = 64;
  localparam int MSG_WORDS = 16;
  localparam int HV_WORDS  = 8;
  localparam int ROUNDS    = 80;
  localparam int RND_W     = $clog2(ROUNDS);
  localparam int BLOCK_W   = WORD_W * MSG_WORDS;
  localparam int HV_W      = WORD_W * HV_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [0:HV_WORDS-1]  hv_t;   // index 0 = a / H0 in msbs
  typedef word_t [0:MSG_WORDS-1] win_t;  // index 0 = oldest word

  localparam hv_t IV = '{
    64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b, 64'h3c6ef372fe94f82b, 64'ha54ff53a5f1d36f1,
    64'h510e527fade682d1, 64'h9b05688c2b3e6c1f, 64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179};

  function automatic word_t ror(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(word_t x); return ror(x,28) ^ ror(x,34) ^ ror(x,39); endfunction
  function automatic word_t big_s1(word_t x); return ror(x,14) ^ ror(x,18) ^ ror(x,41); endfunction
  function automatic word_t sml_s0(word_t x); return ror(x,1)  ^ ror(x,8)  ^ (x >> 7);  endfunction
  function automatic word_t sml_s1(word_t x); return ror(x,19) ^ ror(x,61) ^ (x >> 6);  endfunction

  function automatic bit is_prime(int q);
    bit r = (q > 1);
    for (int d = 2; d < 21; d++) if (d < q && (q % d) == 0) r = 1'b0;
    return r;
  endfunction

  // fractional cube root of the idx-th prime, elaboration time only
  function automatic word_t round_const(int idx);
    int p = 0;
    int cnt = -1;
    logic [255:0] n, r, t;
    for (int q = 2; q < 420; q++) begin
      if (cnt < idx && is_prime(q)) begin
        cnt++;
        if (cnt == idx) p = q;
      end
    end
    n = 256'(p) << 192;
    r = '0;
    for (int b = 67; b >= 0; b--) begin
      t = r | (256'(1) << b);
      if (t * t * t <= n) r = t;
    end
    return r[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/sha512_kconst.sv
module sha512_kconst
  import sha512_pkg::*;
(
  input  logic [RND_W-1:0] idx_i,
  output word_t            k_o
);
  word_t rom [ROUNDS];

  for (genvar i = 0; i < ROUNDS; i++) begin : g_k
    localparam word_t KV = round_const(i);
    assign rom[i] = KV;
  end

  assign k_o = (int'(idx_i) < ROUNDS) ? rom[idx_i] : '0;
endmodule

// File: rtl/sha512_sched.sv
module sha512_sched
  import sha512_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  step_i,
  input  win_t  block_i,
  output word_t w_o
);
  win_t  win_q;
  word_t nxt;

  // W[t+16] from the window holding W[t..t+15]
  assign nxt = sml_s1(win_q[14]) + win_q[9] + sml_s0(win_q[1]) + win_q[0];
  assign w_o = win_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_q <= '0;
    else if (load_i) win_q <= block_i;
    else if (step_i) win_q <= {win_q[1:MSG_WORDS-1], nxt};
  end
endmodule

// File: rtl/sha512_round.sv
module sha512_round
  import sha512_pkg::*;
(
  input  hv_t   cur_i,
  input  word_t k_i,
  input  word_t w_i,
  output hv_t   nxt_o
);
  word_t t1, t2, ch, maj;

  always_comb begin
    ch    = (cur_i[4] & cur_i[5]) ^ (~cur_i[4] & cur_i[6]);
    maj   = (cur_i[0] & cur_i[1]) ^ (cur_i[0] & cur_i[2]) ^ (cur_i[1] & cur_i[2]);
    t1    = cur_i[7] + big_s1(cur_i[4]) + ch + k_i + w_i;
    t2    = big_s0(cur_i[0]) + maj;
    nxt_o = {t1 + t2, cur_i[0], cur_i[1], cur_i[2], cur_i[3] + t1, cur_i[4], cur_i[5], cur_i[6]};
  end
endmodule

// File: rtl/sha512_core.sv
module sha512_core
  import sha512_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               init_hv_i,
  input  logic [BLOCK_W-1:0] block_i,
  input  logic [HV_W-1:0]    hv_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [HV_W-1:0]    digest_o
);
  localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

  logic             busy_q, done_q, accept, last;
  logic [RND_W-1:0] rnd_q;
  hv_t              work_q, chain_q, digest_q, seed, rnd_out, sum;
  word_t            k, w;

  assign accept = start_i && !busy_q;
  assign last   = busy_q && (rnd_q == LAST);
  assign seed   = init_hv_i ? IV : hv_t'(hv_i);

  sha512_kconst u_k (.idx_i(rnd_q), .k_o(k));

  sha512_sched u_sched (
    .clk_i, .rst_ni,
    .load_i (accept),
    .step_i (busy_q),
    .block_i(win_t'(block_i)),
    .w_o    (w)
  );

  sha512_round u_rnd (.cur_i(work_q), .k_i(k), .w_i(w), .nxt_o(rnd_out));

  for (genvar i = 0; i < HV_WORDS; i++) begin : g_fold
    assign sum[i] = chain_q[i] + rnd_out[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rnd_q    <= '0;
      work_q   <= '0;
      chain_q  <= '0;
      digest_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        rnd_q   <= '0;
        work_q  <= seed;
        chain_q <= seed;
      end else if (busy_q) begin
        work_q <= rnd_out;
        rnd_q  <= rnd_q + 1'b1;
        if (last) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          digest_q <= sum;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign digest_o = digest_q;
endmodule

// File: rtl/sha512_core_chk.sv
module sha512_core_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [511:0] digest_o
);
  logic [7:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= '0;
    else if (busy_o) run_len <= (run_len == 8'hff) ? run_len : run_len + 1'b1;
    else             run_len <= '0;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_len == 8'd80) && !busy_o);

  // R3
  busy_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len <= 8'd80);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R7
  digest_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(digest_o) |-> done_o);
endmodule

bind sha512_core sha512_core_chk u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .digest_o);

// File: tb/sim_sha512_core.sv
module sim_sha512_core;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          init_hv_i = 1'b0;
  logic [1023:0] block_i = '0;
  logic [511:0]  hv_i = '0;
  logic          busy_o, done_o;
  logic [511:0]  digest_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] kt [80];

  localparam logic [511:0] IV_TB = {
    64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b, 64'h3c6ef372fe94f82b, 64'ha54ff53a5f1d36f1,
    64'h510e527fade682d1, 64'h9b05688c2b3e6c1f, 64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179};

  always #5 clk_i = ~clk_i;

  sha512_core u0 (.*);

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rr(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  // round constants by integer Newton iteration from above
  task automatic build_k();
    int idx = 0;
    for (int q = 2; idx < 80; q++) begin
      bit pr = 1'b1;
      for (int d = 2; d * d <= q; d++) if (q % d == 0) pr = 1'b0;
      if (pr) begin
        logic [255:0] n = 256'(q) << 192;
        logic [255:0] x = 256'(1) << 68;
        logic [255:0] y;
        bit fin = 1'b0;
        for (int it = 0; it < 300 && !fin; it++) begin
          y = (2 * x + n / (x * x)) / 3;
          if (y >= x) fin = 1'b1; else x = y;
        end
        kt[idx] = x[63:0];
        idx++;
      end
    end
  endtask

  function automatic logic [511:0] model(logic [1023:0] blk, logic [511:0] hv);
    logic [63:0] w [80];
    logic [63:0] v [8];
    logic [63:0] h0 [8];
    logic [63:0] t1, t2;
    logic [511:0] r;
    for (int i = 0; i < 16; i++) w[i] = blk[1023 - 64*i -: 64];
    for (int i = 16; i < 80; i++)
      w[i] = (rr(w[i-2],19) ^ rr(w[i-2],61) ^ (w[i-2] >> 6)) + w[i-7]
           + (rr(w[i-15],1) ^ rr(w[i-15],8) ^ (w[i-15] >> 7)) + w[i-16];
    for (int i = 0; i < 8; i++) begin h0[i] = hv[511 - 64*i -: 64]; v[i] = h0[i]; end
    for (int t = 0; t < 80; t++) begin
      t1 = v[7] + (rr(v[4],14) ^ rr(v[4],18) ^ rr(v[4],41)) + ((v[4] & v[5]) ^ (~v[4] & v[6]))
         + kt[t] + w[t];
      t2 = (rr(v[0],28) ^ rr(v[0],34) ^ rr(v[0],39)) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[511 - 64*i -: 64] = h0[i] + v[i];
    return r;
  endfunction

  function automatic logic [1023:0] rnd_block();
    logic [1023:0] b;
    for (int i = 0; i < 32; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  // one job; inject >= 0 pulses a stray start that many cycles into the run
  task automatic run_job(input logic [1023:0] blk, input logic [511:0] hv, input logic ini,
                         input int inject, output logic [511:0] dig);
    int bcnt = 0;
    int guard = 0;
    @(negedge clk_i);
    block_i = blk; hv_i = hv; init_hv_i = ini; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 busy after start", 512'(busy_o), 512'(1));
    while (!done_o && guard < 300) begin
      if (busy_o) bcnt++;
      if (guard == inject) begin
        start_i = 1'b1; block_i = rnd_block(); hv_i = ~hv; init_hv_i = ~ini;
      end else start_i = 1'b0;
      @(negedge clk_i);
      guard++;
    end
    start_i = 1'b0;
    chk("R3 busy cycles", 512'(bcnt), 512'(80));
    chk("R3 busy low at done", 512'(busy_o), 512'(0));
    dig = digest_o;
    @(negedge clk_i);
    chk("R3 done one cycle", 512'(done_o), 512'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [511:0] d, d2, exp;
    logic [1023:0] b;
    build_k();
    chk("R9 model K0", 512'(kt[0]), 512'(64'h428a2f98d728ae22));
    chk("R9 model K79", 512'(kt[79]), 512'(64'h6c44198c4a475817));

    repeat (3) @(negedge clk_i);
    chk("R8 busy reset", 512'(busy_o), 512'(0));
    chk("R8 done reset", 512'(done_o), 512'(0));
    chk("R8 digest reset", digest_o, '0);
    rst_ni = 1'b1;

    // R9 known vectors; R1 word order fixed by these
    run_job({64'h8000000000000000, 960'b0}, '1, 1'b1, -1, d);
    chk("R9 empty message", d, {64'hcf83e1357eefb8bd, 64'hf1542850d66d8007, 64'hd620e4050b5715dc,
      64'h83f4a921d36ce9ce, 64'h47d0d13c5d85f2b0, 64'hff8318d2877eec2f, 64'h63b931bd47417a81,
      64'ha538327af927da3e});
    b = {64'h6162638000000000, 896'b0, 64'h18};
    run_job(b, '0, 1'b1, -1, d);
    chk("R9 abc", d, {64'hddaf35a193617aba, 64'hcc417349ae204131, 64'h12e6fa4e89a97ea2,
      64'h0a9eeee64b55d39a, 64'h2192992a274fc1a8, 64'h36ba3c23a3feebbd, 64'h454d4423643ce80e,
      64'h2a9ac94fa54ca49f});
    // R1 explicit chaining value equal to IV gives the same result
    run_job(b, IV_TB, 1'b0, -1, d2);
    chk("R1 hv order", d2, d);

    // R4 random blocks and chaining values
    for (int i = 0; i < 6; i++) begin
      logic [511:0] hv = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
        $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      b = rnd_block();
      if (i == 0) begin b = '0; hv = '0; end
      if (i == 1) begin b = '1; hv = '1; end
      run_job(b, hv, 1'b0, -1, d);
      chk("R4 random block", d, model(b, hv));
      // R4 chained second block
      b = rnd_block();
      run_job(b, d, 1'b0, -1, d2);
      chk("R4 chained block", d2, model(b, d));
    end

    // R5 hv_i ignored with init_hv_i
    b = rnd_block();
    run_job(b, {16{32'hdeadbeef}}, 1'b1, -1, d);
    chk("R5 init overrides hv", d, model(b, IV_TB));

    // R6 stray starts during run
    b = rnd_block();
    run_job(b, {16{32'h13579bdf}}, 1'b0, 10, d);
    chk("R6 start while busy ignored", d, model(b, {16{32'h13579bdf}}));
    run_job(b, {16{32'h2468ace0}}, 1'b0, 78, d);
    chk("R6 late start ignored", d, model(b, {16{32'h2468ace0}}));
    chk("R6 no restart", 512'(busy_o), 512'(0));

    // R7 digest holds while idle with inputs changing
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      block_i = rnd_block(); hv_i = ~hv_i; init_hv_i = ~init_hv_i;
    end
    chk("R7 digest held", digest_o, d);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule